// File: doc/BRIEF.md
# Time-of-Day Update and Alarm Unit

This unit keeps a seconds, minutes and hours time of day and moves it forward by one second every `TICKS_PER_SEC` strobes of a prescaled tick input. Each time byte is held in the encoding that software sees. A mode input selects packed BCD or plain binary. A second mode input selects a 24-hour clock, or a 12-hour clock with a PM marker. Every advance produces a one-cycle update pulse. When the freshly advanced time agrees with three alarm bytes, an alarm pulse fires in the same cycle. Any alarm byte can be made a wildcard.

A status output rises for the last `UIP_TICKS` tick strobes before each advance. Software uses it to know when the time bytes can be read safely. A SET input freezes the time so that software can load it through a byte write port. A two-bit divider control holds the prescaler in reset while both bits are high. After the divider is released, the first advance comes half a second later. Calendar and date counting are not part of this block.

Top module: `rtcTimeAlarm`

## Requirements
- R1: After reset the seconds, minutes and hours outputs are 8'h00, and updStb, almStb and uip are 0.
- R2: With binMode=0 each time byte is BCD, with tens in bits 7:4 and units in bits 3:0. With binMode=1 it is an unsigned binary number. Seconds and minutes step 59 to 0 and carry into the next field.
- R3: With hour24=1 the hour counts 0..23 and wraps to 0. With hour24=0 the hour byte holds 1..12 in bits 6:0, and bit 7 set marks PM. Midnight is 12 with bit 7 clear. 11 AM steps to 12 PM, 12 PM steps to 1 PM, and 11 PM steps to 12 AM.
- R4: One advance happens per `TICKS_PER_SEC` cycles in which tickEn is high. Cycles with tickEn low do not count.
- R5: updStb is a one-cycle pulse. The advanced time is visible on the outputs in the same cycle as the pulse.
- R6: almStb pulses together with updStb when every alarm byte either has bits 7:6 equal to 2'b11 (wildcard) or equals the newly advanced time byte. In 12-hour mode this comparison includes the PM bit.
- R7: uip is high exactly during the last `UIP_TICKS` tick positions before an advance, and low in every other position.
- R8: While setMode=1 the time does not advance, no pulses occur, uip is 0 and uieOut is forced to 0. Otherwise uieOut follows uieIn.
- R9: While divCtl=2'b11 no advance occurs and uip is 0. After release, the first advance comes after `TICKS_PER_SEC/2` tick strobes.
- R10: A cycle with wrEn=1 loads wrData into seconds (wrSel=0), minutes (wrSel=1) or hours (wrSel=2). An advance that falls in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled tick strobe |
| divCtl | input | 2 | Divider control; 2'b11 holds the prescaler in reset |
| setMode | input | 1 | Freeze the time for loading |
| binMode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hour24 | input | 1 | 1 = 24-hour clock, 0 = 12-hour clock with PM in bit 7 |
| uieIn | input | 1 | Requested update-interrupt enable |
| wrEn | input | 1 | Time byte write strobe |
| wrSel | input | 2 | Field to write: 0 seconds, 1 minutes, 2 hours |
| wrData | input | 8 | Byte to write |
| almSec | input | 8 | Seconds alarm byte |
| almMin | input | 8 | Minutes alarm byte |
| almHr | input | 8 | Hours alarm byte |
| secOut | output | 8 | Seconds byte |
| minOut | output | 8 | Minutes byte |
| hrOut | output | 8 | Hours byte |
| uip | output | 1 | Update-in-progress status |
| updStb | output | 1 | Update-ended pulse |
| almStb | output | 1 | Alarm pulse |
| uieOut | output | 1 | Effective update-interrupt enable |

## Verification
The bench sweeps every seconds value and every minutes value in both encodings. This separates BCD digit carry from binary wrap and shows that a carry into the next field happens only at 59. Every hour is stepped in all four encoding and hour-format combinations, which catches PM and midnight mistakes that a 24-hour test cannot see. Each alarm byte is tried wildcarded, exactly matching and mismatching in all eight mixes, plus a PM-only mismatch. Interval counts with full-rate and half-rate ticks pin down the prescaler, the uip window width, and the half-second delay after the divider is released.

// File: rtl/rtcTimeAlarm_pkg.sv
package rtcTimeAlarm_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic advance;  // move time forward by one second this cycle
    logic uipWin;   // inside the pre-update window
  } updCtl_t;

  // Encoded byte to a plain count
  function automatic logic [6:0] decField(input logic [7:0] v, input logic binMode);
    if (binMode) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  // Plain count to an encoded byte
  function automatic logic [7:0] encField(input logic [6:0] n, input logic binMode);
    logic [3:0] tens;
    logic [3:0] units;
    tens  = 4'(n / 7'd10);
    units = 4'(n % 7'd10);
    if (binMode) return {1'b0, n};
    return {tens, units};
  endfunction

endpackage

// File: rtl/rtcTimeAlarm_ctrl.sv
module rtcTimeAlarm_ctrl
  import rtcTimeAlarm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] divCtl,
  input  logic       setMode,
  output updCtl_t    ctl,
  output logic       uip
);

  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_POS  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_POS  = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] WIN_START = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] divCnt;
  logic          divHold;
  logic          running;

  assign divHold = (divCtl == 2'b11);
  assign running = !divHold && !setMode;

  // Prescaler: parked at half a second while held, so release gives a 0.5 s first update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= HALF_POS;
    end else if (divHold) begin
      divCnt <= HALF_POS;
    end else if (tickEn) begin
      divCnt <= (divCnt == LAST_POS) ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.advance = tickEn && running && (divCnt == LAST_POS);
    ctl.uipWin  = running && (divCnt >= WIN_START);
  end

  assign uip = ctl.uipWin;

  // R4
  adv_restarts_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> divCnt == '0);

  // R9
  hold_parks_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    divHold |=> divCnt == HALF_POS);

  // R7
  adv_inside_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> uip);

endmodule

// File: rtl/rtcTimeAlarm_dp.sv
module rtcTimeAlarm_dp
  import rtcTimeAlarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  updCtl_t    ctl,
  input  logic       binMode,
  input  logic       hour24,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrData,
  input  logic [7:0] almSec,
  input  logic [7:0] almMin,
  input  logic [7:0] almHr,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hrOut,
  output logic       updStb,
  output logic       almStb
);

  logic [7:0] secReg, minReg, hrReg;
  logic [6:0] curSec, curMin, hrRaw, curHr;
  logic [6:0] nxtSecN, nxtMinN, nxtHrN, hr12;
  logic       secWrap, hrCarry;
  logic [7:0] nxtSec, nxtMin, nxtHr;
  logic       allMatch;

  function automatic logic fieldHit(input logic [7:0] alm, input logic [7:0] tm);
    return (alm[7:6] == 2'b11) || (alm == tm);
  endfunction

  always_comb begin
    curSec = decField(secReg, binMode);
    curMin = decField(minReg, binMode);
    hrRaw  = decField({1'b0, hrReg[6:0]}, binMode);
    if (hour24) curHr = hrRaw;
    else        curHr = ((hrRaw == 7'd12) ? 7'd0 : hrRaw) + (hrReg[7] ? 7'd12 : 7'd0);

    secWrap = (curSec >= 7'd59);
    hrCarry = secWrap && (curMin >= 7'd59);
    nxtSecN = secWrap ? 7'd0 : curSec + 7'd1;
    nxtMinN = (curMin >= 7'd59) ? 7'd0 : curMin + 7'd1;
    nxtHrN  = (curHr >= 7'd23) ? 7'd0 : curHr + 7'd1;

    nxtSec = encField(nxtSecN, binMode);
    nxtMin = secWrap ? encField(nxtMinN, binMode) : minReg;

    if (nxtHrN == 7'd0)      hr12 = 7'd12;
    else if (nxtHrN > 7'd12) hr12 = nxtHrN - 7'd12;
    else                     hr12 = nxtHrN;

    if (!hrCarry)    nxtHr = hrReg;
    else if (hour24) nxtHr = encField(nxtHrN, binMode);
    else             nxtHr = encField(hr12, binMode) | ((nxtHrN >= 7'd12) ? 8'h80 : 8'h00);

    allMatch = fieldHit(almSec, nxtSec) && fieldHit(almMin, nxtMin) && fieldHit(almHr, nxtHr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secReg <= '0;
      minReg <= '0;
      hrReg  <= '0;
      updStb <= 1'b0;
      almStb <= 1'b0;
    end else begin
      updStb <= 1'b0;
      almStb <= 1'b0;
      if (wrEn) begin
        case (wrSel)
          2'd0:    secReg <= wrData;
          2'd1:    minReg <= wrData;
          2'd2:    hrReg  <= wrData;
          default: ;
        endcase
      end else if (ctl.advance) begin
        secReg <= nxtSec;
        minReg <= nxtMin;
        hrReg  <= nxtHr;
        updStb <= 1'b1;
        almStb <= allMatch;
      end
    end
  end

  assign secOut = secReg;
  assign minOut = minReg;
  assign hrOut  = hrReg;

  // R5
  upd_moves_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    updStb |-> secReg != $past(secReg));

  // R8
  idle_keeps_sec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !wrEn) |=> $stable(secReg));

  // R6
  alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    almStb |-> updStb);

endmodule

// File: rtl/rtcTimeAlarm.sv
module rtcTimeAlarm
  import rtcTimeAlarm_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic [1:0] divCtl,
  input  logic       setMode,
  input  logic       binMode,
  input  logic       hour24,
  input  logic       uieIn,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [7:0] wrData,
  input  logic [7:0] almSec,
  input  logic [7:0] almMin,
  input  logic [7:0] almHr,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hrOut,
  output logic       uip,
  output logic       updStb,
  output logic       almStb,
  output logic       uieOut
);

  updCtl_t ctl;

  rtcTimeAlarm_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .divCtl (divCtl),
    .setMode(setMode),
    .ctl    (ctl),
    .uip    (uip)
  );

  rtcTimeAlarm_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .binMode(binMode),
    .hour24 (hour24),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .almSec (almSec),
    .almMin (almMin),
    .almHr  (almHr),
    .secOut (secOut),
    .minOut (minOut),
    .hrOut  (hrOut),
    .updStb (updStb),
    .almStb (almStb)
  );

  assign uieOut = uieIn && !setMode;

endmodule

// File: tb/tb_rtcTimeAlarm.sv
module tb_rtcTimeAlarm;

  localparam int TPS = 16;
  localparam int UIPN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic tickSlow = 1'b0;
  logic [1:0] divCtl = 2'b00;
  logic setMode = 1'b0, binMode = 1'b0, hour24 = 1'b1, uieIn = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] almSec = 8'h00, almMin = 8'h00, almHr = 8'h00;
  logic [7:0] secOut, minOut, hrOut;
  logic uip, updStb, almStb, uieOut;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  always @(negedge clk) tickEn <= tickSlow ? ~tickEn : 1'b1;

  rtcTimeAlarm #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPN)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .divCtl(divCtl), .setMode(setMode),
    .binMode(binMode), .hour24(hour24), .uieIn(uieIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .almSec(almSec), .almMin(almMin), .almHr(almHr),
    .secOut(secOut), .minOut(minOut), .hrOut(hrOut), .uip(uip),
    .updStb(updStb), .almStb(almStb), .uieOut(uieOut)
  );

  function automatic int enc(int n, bit b);
    return b ? n : (((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int encHr(int h, bit b, bit h24);
    int h12;
    if (h24) return enc(h, b);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, b) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeT(input int sel, input int v);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = 8'(v);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadTime(input int h, input int m, input int s);
    @(negedge clk);
    setMode = 1'b1;
    writeT(0, enc(s, binMode));
    writeT(1, enc(m, binMode));
    writeT(2, encHr(h, binMode, hour24));
    @(negedge clk);
    setMode = 1'b0;
  endtask

  // returns number of negedges waited, or -1 on timeout
  task automatic waitUpd(output int n);
    n = -1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (updStb) begin n = i; break; end
    end
    if (n < 0) begin
      nChecks++; nFail++;
      $display("FAIL R4: no update seen, actual none expected pulse");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n, hi, lastUip;
    bit sawUpd, sawUip;
    int eh, em, es;
    logic [7:0] keep;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sec", secOut, 0);
    chk("R1 min", minOut, 0);
    chk("R1 hr", hrOut, 0);
    chk("R1 upd", updStb, 0);
    chk("R1 alm", almStb, 0);
    chk("R1 uip", uip, 0);

    almSec = 8'h3F; almMin = 8'h3F; almHr = 8'h3F;

    // R10 explicit byte load
    @(negedge clk); setMode = 1'b1;
    writeT(0, 8'h45); chk("R10 sec load", secOut, 8'h45);
    writeT(1, 8'h17); chk("R10 min load", minOut, 8'h17);
    writeT(2, 8'h09); chk("R10 hr load", hrOut, 8'h09);
    @(negedge clk); setMode = 1'b0;

    // R2 seconds and minutes sweeps in both encodings
    for (int b = 0; b < 2; b++) begin
      binMode = b[0]; hour24 = 1'b1;
      for (int s = 0; s < 60; s++) begin
        loadTime(5, 7, s);
        waitUpd(n);
        chk("R2 sec step", secOut, enc((s + 1) % 60, binMode));
        chk("R2 sec carry", minOut, enc((s == 59) ? 8 : 7, binMode));
      end
      for (int m = 0; m < 60; m++) begin
        loadTime(5, m, 59);
        waitUpd(n);
        chk("R2 min step", minOut, enc((m + 1) % 60, binMode));
        chk("R2 min carry", hrOut, enc((m == 59) ? 6 : 5, binMode));
      end
    end

    // R3 every hour in all four format combinations
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 2; f++) begin
        binMode = b[0]; hour24 = f[0];
        for (int h = 0; h < 24; h++) begin
          loadTime(h, 59, 59);
          waitUpd(n);
          chk("R3 hour step", hrOut, encHr((h + 1) % 24, binMode, hour24));
          chk("R3 sec zero", secOut, enc(0, binMode));
        end
      end
    end

    // R6 wildcard mixes, exact vs mismatching non-wildcard bytes
    hour24 = 1'b1;
    for (int b = 0; b < 2; b++) begin
      binMode = b[0];
      for (int v = 0; v < 2; v++) begin
        for (int mask = 0; mask < 8; mask++) begin
          es = enc(v == 0 ? 30 : 31, binMode);
          em = enc(v == 0 ? 20 : 21, binMode);
          eh = enc(v == 0 ? 10 : 11, binMode);
          almSec = mask[0] ? 8'hC5 : 8'(es);
          almMin = mask[1] ? 8'hC2 : 8'(em);
          almHr  = mask[2] ? 8'hFF : 8'(eh);
          loadTime(10, 20, 29);
          waitUpd(n);
          chk("R6 alarm mix", almStb, (v == 0 || mask == 7) ? 1 : 0);
        end
      end
    end

    // R6/R3 PM bit takes part in the hour compare
    binMode = 1'b0; hour24 = 1'b0;
    almSec = 8'hC0; almMin = 8'hC0; almHr = 8'h01;
    loadTime(13, 20, 29);
    waitUpd(n);
    chk("R6 pm mismatch", almStb, 0);
    almHr = 8'h81;
    loadTime(13, 20, 29);
    waitUpd(n);
    chk("R6 pm match", almStb, 1);
    almHr = 8'hC0;
    waitUpd(n);
    chk("R6 all wildcard", almStb, 1);

    // R4 and R7 interval and window at full tick rate
    waitUpd(n);
    n = 0; hi = 0; lastUip = 0;
    forever begin
      @(negedge clk); n++;
      if (updStb) break;
      lastUip = uip;
      if (uip) hi++;
    end
    chk("R4 interval", n, TPS);
    chk("R7 window width", hi, UIPN);
    chk("R7 high before update", lastUip, 1);
    chk("R7 low at update", uip, 0);

    // R4 half-rate ticks
    tickSlow = 1'b1;
    waitUpd(n);
    waitUpd(n);
    chk("R4 slow interval", n, 2 * TPS);
    tickSlow = 1'b0;
    waitUpd(n);

    // R8 SET freezes time, blocks pulses and uip, forces enable low
    @(negedge clk);
    setMode = 1'b1; uieIn = 1'b1;
    keep = secOut; sawUpd = 0; sawUip = 0;
    repeat (40) begin
      @(negedge clk);
      if (updStb) sawUpd = 1;
      if (uip) sawUip = 1;
    end
    chk("R8 time frozen", secOut, keep);
    chk("R8 no update", sawUpd, 0);
    chk("R8 uip low", sawUip, 0);
    chk("R8 uie forced", uieOut, 0);
    setMode = 1'b0;
    @(negedge clk);
    chk("R8 uie follows", uieOut, 1);

    // R9 divider hold and half-second restart
    @(negedge clk);
    divCtl = 2'b11; sawUpd = 0; sawUip = 0;
    repeat (40) begin
      @(negedge clk);
      if (updStb) sawUpd = 1;
      if (uip) sawUip = 1;
    end
    chk("R9 no update held", sawUpd, 0);
    chk("R9 uip low held", sawUip, 0);
    divCtl = 2'b00;
    waitUpd(n);
    chk("R9 first update delay", n, TPS / 2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule